// File: doc/BRIEF.md
# Nibble-Serial CRC-16 Engine for Serial-Bus Control Structures

This block computes the 16-bit check value that protects the control and status structures of a serial bus node: topology map, speed map and configuration ROM blocks. A caller streams the quadlets that the check covers, which are the ones after the header. The engine folds each quadlet into a 16-bit register four bits at a time, starting with the most significant nibble. The fold uses a shift-and-XOR step with feedback into bits 12, 5 and 0.

A block opens with a start strobe, which can travel with its first quadlet, and closes with a last flag on its final quadlet. A ready output is low while a quadlet is being folded, so the caller can present one quadlet every eight clocks. When the final nibble of the block is folded, a one-cycle valid pulse marks the result. A header output places the number of covered quadlets in the upper half and the check value in the lower half, so the caller can store it directly in front of the block. For example, a speed map covers 0x3F1 quadlets, and a topology map covers its self-ID count plus two.

Top module: `csr_crc_engine`

## Requirements
- R1: After reset, crc_o and hdr_o are zero, in_ready_o is 1 and crc_valid_o is 0.
- R2: start_i clears the check register and the quadlet count to zero. If in_valid_i is high in the same cycle, that quadlet is accepted as the first of the new block, even when in_ready_o is low.
- R3: Each accepted quadlet is folded as eight nibbles, bits 31:28 first and bits 3:0 last. Each nibble n updates the register c as follows: s = c[15:12] XOR n; c = (c<<4) XOR (s<<12) XOR (s<<5) XOR s, truncated to 16 bits.
- R4: A quadlet is accepted on a clock edge where in_valid_i and in_ready_o are both high. in_ready_o then stays low for the next 7 clocks, so one quadlet is accepted every 8 clocks.
- R5: in_valid_i is ignored while in_ready_o is low and start_i is low. Neither the check value nor the count changes because of it.
- R6: crc_valid_o is high for exactly one cycle. That cycle begins at the 8th edge counted from the acceptance of the quadlet flagged with in_last_i (the acceptance edge counts as the 1st). In that cycle in_ready_o is high.
- R7: hdr_o[31:16] holds the number of quadlets accepted since the last start, and hdr_o[15:0] equals crc_o. This holds for long blocks such as 0x3F1 quadlets.
- R8: start_i without in_valid_i during a computation aborts it: on the next cycle in_ready_o is 1, crc_o is 0, and no crc_valid_o pulse follows.
- R9: While idle with no input strobes, crc_o and hdr_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new block (clears register and count) |
| in_valid_i | input | 1 | Quadlet present on in_data_i |
| in_last_i | input | 1 | Quadlet is the final one of the block |
| in_data_i | input | 32 | Quadlet to fold |
| in_ready_o | output | 1 | Engine can accept a quadlet |
| crc_o | output | 16 | Running check value |
| crc_valid_o | output | 1 | One-cycle pulse: block check value complete |
| hdr_o | output | 32 | Header quadlet: count in 31:16, check value in 15:0 |

## Verification
The assertions assume that start_i and in_valid_i carry known values after reset. They also assume that a caller asserts start_i for a single cycle, because several of them relate the cycle after a start to the inputs of that start cycle. The bench changes inputs only on falling edges and pulses start_i for exactly one clock. It holds in_valid_i for a single acceptance cycle, except in the test that drives it on purpose while the engine is busy, to show that it is ignored.

// File: rtl/csr_crc_pkg.sv
package csr_crc_pkg;
  localparam int CRC_W = 16;
  localparam int NIB_W = 4;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/csr_crc_step.sv
module csr_crc_step
  import csr_crc_pkg::*;
(
  input  crc_t             crc_i,
  input  logic [NIB_W-1:0] nib_i,
  output crc_t             crc_o
);
  logic [NIB_W-1:0] sum;

  always_comb begin
    sum   = crc_i[CRC_W-1 -: NIB_W] ^ nib_i;
    // taps at bit 12, 5 and 0
    crc_o = {crc_i[CRC_W-NIB_W-1:0], {NIB_W{1'b0}}}
          ^ {sum, 12'b0}
          ^ {7'b0, sum, 5'b0}
          ^ {12'b0, sum};
  end
endmodule

// File: rtl/csr_crc_seq.sv
module csr_crc_seq
  import csr_crc_pkg::*;
#(
  parameter int QUAD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  input  logic [QUAD_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              accept_o,
  output logic              step_o,
  output logic [NIB_W-1:0]  nib_o,
  output logic              done_o
);
  localparam int NIBS  = QUAD_W / NIB_W;
  localparam int CNT_W = $clog2(NIBS);

  logic              busy_q, last_q, done_q;
  logic [CNT_W-1:0]  remain_q;
  logic [QUAD_W-1:0] shreg_q;

  assign in_ready_o = !busy_q;
  assign accept_o   = in_valid_i && (!busy_q || start_i);
  assign step_o     = accept_o || (busy_q && !start_i);
  assign nib_o      = accept_o ? in_data_i[QUAD_W-1 -: NIB_W] : shreg_q[QUAD_W-1 -: NIB_W];
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      remain_q <= '0;
      shreg_q  <= '0;
    end else if (accept_o) begin
      // first nibble is folded on the accept edge
      shreg_q  <= in_data_i << NIB_W;
      remain_q <= CNT_W'(NIBS - 1);
      busy_q   <= 1'b1;
      last_q   <= in_last_i;
      done_q   <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else if (busy_q) begin
      shreg_q  <= shreg_q << NIB_W;
      remain_q <= remain_q - 1'b1;
      if (remain_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= last_q;
      end else begin
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/csr_crc_engine.sv
module csr_crc_engine
  import csr_crc_pkg::*;
#(
  parameter int QUAD_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   in_valid_i,
  input  logic                   in_last_i,
  input  logic [QUAD_W-1:0]      in_data_i,
  output logic                   in_ready_o,
  output logic [CRC_W-1:0]       crc_o,
  output logic                   crc_valid_o,
  output logic [LEN_W+CRC_W-1:0] hdr_o
);
  logic             accept, step;
  logic [NIB_W-1:0] nib;
  crc_t             crc_q, crc_base, crc_next;
  logic [LEN_W-1:0] len_q;

  csr_crc_seq #(.QUAD_W(QUAD_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .in_data_i  (in_data_i),
    .in_ready_o (in_ready_o),
    .accept_o   (accept),
    .step_o     (step),
    .nib_o      (nib),
    .done_o     (crc_valid_o)
  );

  assign crc_base = start_i ? '0 : crc_q;

  csr_crc_step u_step (
    .crc_i (crc_base),
    .nib_i (nib),
    .crc_o (crc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
      len_q <= '0;
    end else begin
      if (step)         crc_q <= crc_next;
      else if (start_i) crc_q <= '0;
      if (start_i)      len_q <= accept ? LEN_W'(1) : '0;
      else if (accept)  len_q <= len_q + 1'b1;
    end
  end

  assign crc_o = crc_q;
  assign hdr_o = {len_q, crc_q};
endmodule

// File: rtl/csr_crc_engine_chk.sv
module csr_crc_engine_chk #(
  parameter int LEN_W = 16,
  parameter int CRC_W = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   start_i,
  input logic                   in_valid_i,
  input logic                   in_ready_o,
  input logic                   crc_valid_o,
  input logic [CRC_W-1:0]       crc_o,
  input logic [LEN_W+CRC_W-1:0] hdr_o
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_valid_o |=> !crc_valid_o); // R6
  AST_VALID_WITH_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_valid_o |-> in_ready_o); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && !start_i) |=> !in_ready_o); // R4
  AST_START_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> hdr_o[LEN_W+CRC_W-1:CRC_W] == {{(LEN_W-1){1'b0}}, $past(in_valid_i)}); // R2
  AST_ABORT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !in_valid_i) |=> (in_ready_o && crc_o == '0 && !crc_valid_o)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i && !start_i) |=> ($stable(crc_o) && $stable(hdr_o))); // R9
endmodule

bind csr_crc_engine csr_crc_engine_chk #(.LEN_W(LEN_W), .CRC_W(csr_crc_pkg::CRC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .crc_valid_o (crc_valid_o),
  .crc_o       (crc_o),
  .hdr_o       (hdr_o)
);

// File: tb/csr_crc_engine_test.sv
module csr_crc_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, crc_valid;
  logic [15:0] crc;
  logic [31:0] hdr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  csr_crc_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .in_valid_i(in_valid),
    .in_last_i(in_last), .in_data_i(in_data), .in_ready_o(in_ready),
    .crc_o(crc), .crc_valid_o(crc_valid), .hdr_o(hdr)
  );

  localparam logic [95:0] VEC [6] = '{
    96'h0000_0000_0000_0000_0000_0000,
    96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
    96'h0000_0001_0000_0000_0000_0000,
    96'h8000_0000_0000_0000_0000_0001,
    96'h1234_5678_9ABC_DEF0_0F1E_2D3C,
    96'hDEAD_BEEF_0000_0003_A5A5_5A5A
  };

  function automatic logic [15:0] model(input logic [15:0] c0, input logic [31:0] q);
    logic [15:0] c, s;
    c = c0;
    for (int i = 7; i >= 0; i--) begin
      s = {12'b0, c[15:12] ^ q[i*4 +: 4]};
      c = (c << 4) ^ (s << 12) ^ (s << 5) ^ s;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one quadlet at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [31:0] q, input logic lst, input logic st);
    @(negedge clk);
    while (!in_ready && !st) @(negedge clk);
    in_valid = 1'b1; in_data = q; in_last = lst; start = st;
    @(negedge clk);
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; start = 1'b0;
  endtask

  task automatic finish_summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_summary();
  end

  initial begin
    logic [15:0] exp_c, held;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 crc", {16'b0, crc}, 32'h0);
    chk("R1 hdr", hdr, 32'h0);
    chk("R1 ready", {31'b0, in_ready}, 32'h1);
    chk("R1 valid", {31'b0, crc_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 folding, R4 handshake, R6 pulse, R7 header
    for (int k = 0; k < 6; k++) begin
      exp_c = 16'h0;
      for (int j = 0; j < 3; j++) begin
        send(VEC[k][95-32*j -: 32], j == 2, j == 0);
        exp_c = model(exp_c, VEC[k][95-32*j -: 32]);
        chk("R4 ready low after accept", {31'b0, in_ready}, 32'h0);
        repeat (6) @(negedge clk);
        chk("R4 ready still low", {31'b0, in_ready}, 32'h0);
        chk("R6 no early valid", {31'b0, crc_valid}, 32'h0);
        @(negedge clk);
        chk("R4 ready back high", {31'b0, in_ready}, 32'h1);
        chk("R6 valid on last only", {31'b0, crc_valid}, {31'b0, j == 2});
      end
      chk("R3 crc value", {16'b0, crc}, {16'b0, exp_c});
      chk("R7 header", hdr, {16'd3, exp_c});
      @(negedge clk);
      chk("R6 valid single cycle", {31'b0, crc_valid}, 32'h0);
    end

    // R9 idle hold
    held = crc;
    repeat (10) @(negedge clk);
    chk("R9 crc held", {16'b0, crc}, {16'b0, held});
    chk("R9 hdr held", hdr, {16'd3, held});

    // R5 valid during busy ignored
    send(32'hCAFE_F00D, 1'b1, 1'b1);
    in_valid = 1'b1; in_data = 32'h5555_AAAA; in_last = 1'b0;
    repeat (7) @(negedge clk);
    in_valid = 1'b0; in_data = '0;
    chk("R5 crc unaffected", {16'b0, crc}, {16'b0, model(16'h0, 32'hCAFE_F00D)});
    chk("R5 count unaffected", {16'b0, hdr[31:16]}, 32'h1);
    chk("R5 valid", {31'b0, crc_valid}, 32'h1);

    // R8 abort with start alone
    send(32'h0123_4567, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 ready", {31'b0, in_ready}, 32'h1);
    chk("R8 crc zero", {16'b0, crc}, 32'h0);
    chk("R8 hdr zero", hdr, 32'h0);
    for (int i = 0; i < 8; i++) begin
      chk("R8 no valid pulse", {31'b0, crc_valid}, 32'h0);
      @(negedge clk);
    end

    // R2 start with quadlet while busy restarts block
    send(32'hFEDC_BA98, 1'b0, 1'b1);
    repeat (3) @(negedge clk);
    send(32'h1357_9BDF, 1'b1, 1'b1);
    repeat (7) @(negedge clk);
    chk("R2 restart crc", {16'b0, crc}, {16'b0, model(16'h0, 32'h1357_9BDF)});
    chk("R2 restart count", {16'b0, hdr[31:16]}, 32'h1);
    chk("R2 restart valid", {31'b0, crc_valid}, 32'h1);

    // R7 long block of 0x3F1 quadlets
    exp_c = 16'h0;
    for (int i = 0; i < 16'h3F1; i++) begin
      logic [31:0] q;
      q = (32'h9E37_79B9 * i) ^ i;
      send(q, i == 16'h3F0, i == 0);
      exp_c = model(exp_c, q);
      repeat (7) @(negedge clk);
    end
    chk("R7 long valid", {31'b0, crc_valid}, 32'h1);
    chk("R7 long header", hdr, {16'h03F1, exp_c});

    finish_summary();
  end
endmodule